// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable behavioural model of a synchronous, pipelined static RAM whose data bus never needs an idle cycle when traffic switches between reads and writes. A host presents one command per clock: load a new address as a read, load it as a write, load a deselect, or advance the current burst. Read data leaves the output register after the edge that follows the command edge. Write data is taken from the shared bus on the second edge after the command. Both kinds of traffic therefore occupy the same bus slot, one command edge later, and any mix of reads and writes can run at full rate.

The data bus is bidirectional and split into byte lanes of `LANE_W` bits. A burst counter produces the following addresses of a burst of `2**BURST_W` words. It counts in linear or interleaved order. An active-low clock enable freezes the whole pipeline. An asynchronous output enable can release the bus at any time. A read that follows a write to the same word gets the new bytes, because the array forwards them from the write stage as that write commits.

Top module: `noturn_sram`

## Requirements
- R1: While reset is asserted, and after reset until the first read reaches the output stage, the block does not drive `dq_io`.
- R2: A read loaded at clock edge n with `oe_ni` low drives the word at its address on `dq_io` after edge n+1, until the next enabled edge.
- R3: A write loaded at edge n stores the bus contents at edge n+2. Lane i is bits [LANE_W*i+LANE_W-1 : LANE_W*i], and it is stored only when `bw_ni[i]` was low at edge n. With all `bw_ni` bits high, no lane changes.
- R4: Reads and writes can be loaded on consecutive edges in any order without idle cycles. The block never drives the bus in a write slot.
- R5: A read loaded on the edge right after a write to the same address returns the newly written lanes and the old contents of the lanes that were not written.
- R6: The block is selected only when `cs1_ni`=0, `cs2_i`=1 and `cs2_ni`=0. A load edge with `adv_i`=0 that is not selected is a deselect: nothing is written and the bus is not driven.
- R7: With `adv_i`=1 the current burst continues at the next address. The address bits above the low `BURST_W` bits keep the loaded value. With `lbo_ni`=0 the low bits are start+count modulo 2**BURST_W. With `lbo_ni`=1 they are start XOR count. The sequence wraps to the start address after 2**BURST_W words.
- R8: An advance that follows a deselect stays a deselect: it neither writes nor drives.
- R9: On an edge with `cke_ni`=1 every synchronous input is ignored and all pipeline state holds. Read data stays on the bus, and a pending write slot moves out by one edge.
- R10: `oe_ni`=1 releases `dq_io` at once, without waiting for a clock. A read seen with `oe_ni` high is a dummy read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the pipeline |
| cke_ni | input | 1 | Active-low clock enable; high stalls the block |
| cs1_ni | input | 1 | Active-low chip select |
| cs2_i | input | 1 | Active-high chip select |
| cs2_ni | input | 1 | Second active-low chip select |
| adv_i | input | 1 | 0 loads a new command, 1 advances the burst |
| we_ni | input | 1 | Active-low write enable, used on load edges |
| bw_ni | input | LANES | Active-low per-lane write enables |
| addr_i | input | ADDR_W | Word address, used on load edges |
| lbo_ni | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous active-low output enable |
| dq_io | inout | LANES*LANE_W | Shared data bus |

## Verification
Every command gets one bus slot, in the half cycle after the enabled edge that follows its command edge. Read data is checked there. Write data is driven there and captured at the next enabled edge. The bench keeps a two-entry model of the pipeline that shifts only on edges with the clock enable low, so stalls push the slot out exactly as R9 requires. In each slot it samples `dq_io` one nanosecond after setting the output enable and its own driver, well clear of the rising edge. Idle and dummy-read slots are checked by driving a known probe pattern from the bench and reading it back unchanged, which catches any drive from the block.

// File: rtl/noturn_pkg.sv
package noturn_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/noturn_cmd.sv
module noturn_cmd
  import noturn_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              lbo_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output logic [LANES-1:0]  s1_mask_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nxt, lo_nxt;
  op_e                kind_q, load_op;

  assign cnt_nxt = cnt_q + 1'b1;
  assign lo_nxt  = lbo_ni ? (base_q[BURST_W-1:0] ^ cnt_nxt)
                          : (base_q[BURST_W-1:0] + cnt_nxt);
  assign load_op = !sel_i ? OP_IDLE : (we_ni ? OP_READ : OP_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      cnt_q     <= '0;
      kind_q    <= OP_IDLE;
      s1_op_o   <= OP_IDLE;
      s1_addr_o <= '0;
      s1_mask_o <= '0;
    end else if (step_i) begin
      s1_mask_o <= ~bw_ni;
      if (!adv_i) begin
        base_q    <= addr_i;
        cnt_q     <= '0;
        kind_q    <= load_op;
        s1_op_o   <= load_op;
        s1_addr_o <= addr_i;
      end else begin
        // burst type (incl. deselect) persists across advances
        cnt_q     <= cnt_nxt;
        s1_op_o   <= kind_q;
        s1_addr_o <= {base_q[ADDR_W-1:BURST_W], lo_nxt};
      end
    end
  end
endmodule

// File: rtl/noturn_wstage.sv
module noturn_wstage
  import noturn_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  op_e               s1_op_i,
  input  logic [ADDR_W-1:0] s1_addr_i,
  input  logic [LANES-1:0]  s1_mask_i,
  output logic              w2_vld_o,
  output logic [ADDR_W-1:0] w2_addr_o,
  output logic [LANES-1:0]  w2_mask_o,
  output logic              commit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w2_vld_o  <= 1'b0;
      w2_addr_o <= '0;
      w2_mask_o <= '0;
    end else if (step_i) begin
      w2_vld_o  <= (s1_op_i == OP_WRITE);
      w2_addr_o <= s1_addr_i;
      w2_mask_o <= s1_mask_i;
    end
  end

  // data for this slot is on the bus at the next enabled edge
  assign commit_o = step_i && w2_vld_o;
endmodule

// File: rtl/noturn_array.sv
module noturn_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_mask_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic addr_hit;
  assign addr_hit = wr_en_i && (wr_addr_i == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_mask_i[g])
        mem_q[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
    end

    // bypass the lane being committed on this same edge
    assign rd_data_o[g*LANE_W +: LANE_W] = (addr_hit && wr_mask_i[g])
        ? wr_data_i[g*LANE_W +: LANE_W] : mem_q[rd_addr_i];
  end
endmodule

// File: rtl/noturn_sram.sv
module noturn_sram
  import noturn_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 8,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    cs1_ni,
  input  logic                    cs2_i,
  input  logic                    cs2_ni,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    lbo_ni,
  input  logic                    oe_ni,
  inout  wire  [LANES*LANE_W-1:0] dq_io
);
  localparam int DATA_W = LANES * LANE_W;

  logic              step, sel;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr, w2_addr;
  logic [LANES-1:0]  s1_mask, w2_mask;
  logic              w2_vld_q, commit;
  logic [DATA_W-1:0] rd_data, out_q;
  logic              rd_vld_q;

  assign step = !cke_ni;
  assign sel  = !cs1_ni && cs2_i && !cs2_ni;

  noturn_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_cmd (
    .clk_i, .rst_ni, .step_i(step), .sel_i(sel), .adv_i, .we_ni, .bw_ni,
    .lbo_ni, .addr_i, .s1_op_o(s1_op), .s1_addr_o(s1_addr), .s1_mask_o(s1_mask)
  );

  noturn_wstage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wstage (
    .clk_i, .rst_ni, .step_i(step), .s1_op_i(s1_op), .s1_addr_i(s1_addr),
    .s1_mask_i(s1_mask), .w2_vld_o(w2_vld_q), .w2_addr_o(w2_addr),
    .w2_mask_o(w2_mask), .commit_o(commit)
  );

  noturn_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .wr_en_i(commit), .wr_addr_i(w2_addr), .wr_mask_i(w2_mask),
    .wr_data_i(dq_io), .rd_addr_i(s1_addr), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      out_q    <= '0;
    end else if (step) begin
      rd_vld_q <= (s1_op == OP_READ);
      if (s1_op == OP_READ) out_q <= rd_data;
    end
  end

  assign dq_io = (rd_vld_q && !oe_ni) ? out_q : {DATA_W{1'bz}};
endmodule

// File: rtl/noturn_sram_chk.sv
module noturn_sram_chk
  import noturn_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 72,
  parameter int BURST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_ni,
  input logic              adv_i,
  input logic              cs1_ni,
  input logic              cs2_i,
  input logic              cs2_ni,
  input logic [1:0]        s1_op,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              rd_vld_q,
  input logic              w2_vld_q,
  input logic [ADDR_W-1:0] w2_addr,
  input logic [DATA_W-1:0] out_q
);
  p_rd_stage_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s1_op == OP_READ) |=> rd_vld_q);

  p_wr_stage_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s1_op == OP_WRITE) |=> (w2_vld_q && w2_addr == $past(s1_addr)));

  p_slot_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_vld_q && w2_vld_q));

  p_desel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && !(!cs1_ni && cs2_i && !cs2_ni)) |=> s1_op == OP_IDLE);

  p_adv_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_i) |=> s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W]));

  p_cont_desel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_i && s1_op == OP_IDLE) |=> s1_op == OP_IDLE);

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(out_q) && $stable(rd_vld_q) && $stable(s1_addr) && $stable(w2_vld_q)));
endmodule

bind noturn_sram noturn_sram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(LANES * LANE_W), .BURST_W(BURST_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_ni(cke_ni), .adv_i(adv_i),
  .cs1_ni(cs1_ni), .cs2_i(cs2_i), .cs2_ni(cs2_ni), .s1_op(s1_op),
  .s1_addr(s1_addr), .rd_vld_q(rd_vld_q), .w2_vld_q(w2_vld_q),
  .w2_addr(w2_addr), .out_q(out_q)
);

// File: tb/noturn_sram_tb_top.sv
module noturn_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, LN = 8, LW = 9, DW = LN * LW;
  localparam logic [2:0] K_NOP = 3'd0, K_DS1 = 3'd1, K_RD = 3'd2, K_WR = 3'd3,
                         K_ADV = 3'd4, K_DS2 = 3'd5, K_DS3 = 3'd6;
  localparam logic [DW-1:0] PROBE = {LN{9'h0A5}};
  // entry: kind[27:25] addr[24:19] bw_n[18:11] seed[10:2] oe_n[1] lbo_n[0]
  localparam int NV = 34;
  localparam logic [27:0] VEC [NV] = '{
    {K_WR,  6'd4,  8'h00, 9'h101, 1'b0, 1'b0},
    {K_WR,  6'd9,  8'h00, 9'h0A3, 1'b0, 1'b0},
    {K_WR,  6'd5,  8'h00, 9'h0C7, 1'b0, 1'b0},
    {K_RD,  6'd4,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_WR,  6'd4,  8'hF0, 9'h155, 1'b0, 1'b0},
    {K_RD,  6'd4,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd9,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_WR,  6'd9,  8'hFF, 9'h1FF, 1'b0, 1'b0},
    {K_RD,  6'd9,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_WR,  6'd18, 8'h00, 9'h011, 1'b0, 1'b0},
    {K_ADV, 6'd0,  8'h00, 9'h022, 1'b0, 1'b0},
    {K_ADV, 6'd0,  8'h00, 9'h033, 1'b0, 1'b0},
    {K_ADV, 6'd0,  8'h00, 9'h044, 1'b0, 1'b0},
    {K_RD,  6'd17, 8'h00, 9'h000, 1'b0, 1'b1},
    {K_ADV, 6'd0,  8'h00, 9'h000, 1'b0, 1'b1},
    {K_NOP, 6'd0,  8'h00, 9'h000, 1'b0, 1'b1},
    {K_ADV, 6'd0,  8'h00, 9'h000, 1'b0, 1'b1},
    {K_ADV, 6'd0,  8'h00, 9'h000, 1'b0, 1'b1},
    {K_ADV, 6'd0,  8'h00, 9'h000, 1'b0, 1'b1},
    {K_DS1, 6'd4,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_ADV, 6'd0,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd4,  8'h00, 9'h000, 1'b1, 1'b0},
    {K_DS2, 6'd9,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd9,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_DS3, 6'd9,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd9,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_WR,  6'd30, 8'h00, 9'h0F0, 1'b0, 1'b0},
    {K_NOP, 6'd0,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_NOP, 6'd0,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd30, 8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd5,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd19, 8'h00, 9'h000, 1'b0, 1'b0},
    {K_RD,  6'd4,  8'h00, 9'h000, 1'b0, 1'b0},
    {K_DS1, 6'd0,  8'h00, 9'h000, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_n, cs1_n, cs2, cs2_n, adv, we_n, lbo_n, oe_n;
  logic [LN-1:0] bw_n;
  logic [AW-1:0] addr;
  logic tb_en;
  logic [DW-1:0] tb_val;
  wire  [DW-1:0] dq;
  assign dq = tb_en ? tb_val : {DW{1'bz}};

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mdl [64];
  int p1_k, p2_k;
  logic [DW-1:0] p1_d, p2_d;
  logic p1_oe, p2_oe;
  string p1_t, p2_t;
  int b_kind;
  logic [AW-1:0] b_base;
  logic [1:0] b_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  noturn_sram dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n), .cs1_ni(cs1_n), .cs2_i(cs2),
    .cs2_ni(cs2_n), .adv_i(adv), .we_ni(we_n), .bw_ni(bw_n), .addr_i(addr),
    .lbo_ni(lbo_n), .oe_ni(oe_n), .dq_io(dq)
  );

  function automatic logic [DW-1:0] pat(input logic [8:0] s);
    logic [DW-1:0] r;
    for (int l = 0; l < LN; l++) r[l*LW +: LW] = s + 9'(l * 17);
    return r;
  endfunction

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 4, 7, 8: return "R3";
      3, 6:             return "R4";
      5:                return "R5";
      15, 27, 28, 29:   return "R9";
      19, 22, 23, 24, 25, 32: return "R6";
      20, 30:           return "R8";
      21:               return "R10";
      default:          return "R7";
    endcase
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bus slot, for the command two enabled edges back
  task automatic slot();
    case (p2_k)
      2: begin
        tb_en = 1'b0; oe_n = p2_oe;
        if (!p2_oe) begin #1 check(p2_t, dq, p2_d); end
        else begin tb_en = 1'b1; tb_val = ~p2_d; #1 check("R10", dq, ~p2_d); end
      end
      3: begin
        tb_en = 1'b1; tb_val = p2_d; oe_n = 1'b0;
        #1 check("R4", dq, p2_d);
      end
      default: begin
        tb_en = 1'b1; tb_val = PROBE; oe_n = 1'b0;
        #1 check(p2_t, dq, PROBE);
      end
    endcase
  endtask

  task automatic apply(input logic [27:0] e, input string tag);
    logic [2:0] k;
    logic [AW-1:0] a;
    logic [LN-1:0] bw;
    int nk;
    logic [DW-1:0] nd;
    k = e[27:25]; a = e[24:19]; bw = e[18:11];
    cke_n = 1'b0; cs1_n = 1'b0; cs2 = 1'b1; cs2_n = 1'b0; adv = 1'b0;
    we_n = 1'b1; bw_n = bw; addr = a; lbo_n = e[0];
    nk = 0; nd = '0;
    case (k)
      K_NOP: begin cke_n = 1'b1; we_n = 1'b0; addr = 6'd4; bw_n = '0; end
      K_DS1, K_DS2, K_DS3: begin
        if (k == K_DS1) cs1_n = 1'b1;
        if (k == K_DS2) cs2 = 1'b0;
        if (k == K_DS3) cs2_n = 1'b1;
        we_n = 1'b0; bw_n = '0;
        b_kind = 0; b_base = a; b_cnt = 2'd0;
      end
      K_RD: begin b_kind = 2; b_base = a; b_cnt = 2'd0; nk = 2; end
      K_WR: begin we_n = 1'b0; b_kind = 3; b_base = a; b_cnt = 2'd0; nk = 3; end
      default: begin
        adv = 1'b1; we_n = (b_kind == 2) ? 1'b0 : 1'b1;
        b_cnt = b_cnt + 2'd1;
        a = {b_base[AW-1:2], e[0] ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
        addr = 6'd63;
        nk = b_kind;
      end
    endcase
    if (nk == 2) nd = mdl[a];
    if (nk == 3) begin
      nd = pat(e[10:2]);
      for (int l = 0; l < LN; l++)
        if (!bw[l]) mdl[a][l*LW +: LW] = nd[l*LW +: LW];
    end
    if (k != K_NOP) begin
      p2_k = p1_k; p2_d = p1_d; p2_oe = p1_oe; p2_t = p1_t;
      p1_k = nk; p1_d = nd; p1_oe = e[1]; p1_t = tag;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cke_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b1; cs2_n = 1'b0; adv = 1'b0;
    we_n = 1'b1; bw_n = '1; addr = '0; lbo_n = 1'b0; oe_n = 1'b0;
    tb_en = 1'b0; tb_val = '0;
    p1_k = 0; p2_k = 0; p1_d = '0; p2_d = '0; p1_oe = 1'b0; p2_oe = 1'b0;
    p1_t = "R1"; p2_t = "R1"; b_kind = 0; b_base = '0; b_cnt = '0;
    repeat (3) @(negedge clk);
    slot();                         // R1: bus released in reset
    rst_n = 1'b1;
    @(negedge clk);
    slot();                         // R1: still released after reset
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      slot();
      apply(VEC[i], vec_tag(i));
    end
    // directed: read of 9, then stall so data stays on the bus
    @(negedge clk); slot(); apply({K_RD, 6'd9, 8'h00, 9'h000, 1'b0, 1'b0}, "R10");
    @(negedge clk); slot(); apply({K_DS1, 6'd0, 8'h00, 9'h000, 1'b0, 1'b0}, "R6");
    @(negedge clk); slot(); apply({K_NOP, 6'd0, 8'h00, 9'h000, 1'b0, 1'b0}, "R9");
    @(negedge clk);
    check("R9", dq, mdl[9]);        // held through the stall edge
    #1 oe_n = 1'b1; tb_en = 1'b1; tb_val = ~mdl[9];
    #1 check("R10", dq, ~mdl[9]);   // released without a clock edge
    tb_en = 1'b0; oe_n = 1'b0;
    #1 check("R10", dq, mdl[9]);
    rst_n = 1'b0; tb_en = 1'b1; tb_val = PROBE;
    #1 check("R1", dq, PROBE);      // reset releases the bus at once
    finish_run();
  end
endmodule